// File: doc/BRIEF.md
# Break-Protected Status Flag Bank

This block holds a bank of independent peripheral status flags. A hardware event pulse sets a flag. Software clears it with two accesses. The first is a read of the shared status register while the flag is 1, which arms that flag. The second is a read or write of the data register that belongs to the flag, which clears it if it is armed.

A debug break input tells the block when the processor is halted. A clear-enable bit, written through a simple strobe, decides what break does. While break is high and the bit is 0, no access arms or clears anything, so a debugger can read and write registers freely and flag state is kept. While break is high and the bit is 1, the sequence works as it does outside break. A flag that was armed before break stays armed through break. After break ends, the second access clears it normally. A flag cleared during break stays cleared after break ends.

There is no data stream here. All pins are plain, single-cycle control and status pins, so there is no valid/ready back-pressure.

Top module: `brkprot_flag_bank`

## Requirements
- R1: An event pulse on `evt_set[i]` makes `flags[i]` 1 on the next cycle. If a clearing access to the same flag occurs in the same cycle, the flag still ends up 1.
- R2: A `stat_rd` pulse while `flags[i]` is 1 arms flag i. A later `data_acc[i]` pulse clears `flags[i]` on the following cycle. A `data_acc[i]` pulse on an unarmed flag leaves it at 1.
- R3: A `stat_rd` pulse while `flags[i]` is 0 does not arm flag i, even if the flag is set afterwards.
- R4: While `brk_active` is 1 and `clr_en` is 0, no flag falls. In that condition, `stat_rd` does not arm a flag and `data_acc` does not clear one, even if the flag is already armed.
- R5: While `brk_active` is 1 and `clr_en` is 1, the two-step clear works as in R2.
- R6: A flag cleared during break stays 0 after `brk_active` returns to 0.
- R7: An arm taken before break survives a break with `clr_en` at 0. The first `data_acc[i]` after break ends clears the flag.
- R8: An event on an armed flag drops its arm. A following `data_acc[i]` without a new `stat_rd` leaves the flag at 1.
- R9: A synchronous active-high `rst` makes all flags 0, all arms 0 and `clr_en` 0 on the next cycle.
- R10: A `data_acc[j]` access never clears a flag i other than j.
- R11: An `en_we` pulse loads `en_wd` into `clr_en` on the next cycle. No other input changes `clr_en` except `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | N | Per-flag hardware set events |
| brk_active | input | 1 | Debug break is in effect |
| en_we | input | 1 | Write strobe for the clear-enable bit |
| en_wd | input | 1 | Value written to the clear-enable bit |
| stat_rd | input | 1 | Status register read strobe (first step) |
| data_acc | input | N | Per-flag data register access strobe (second step) |
| flags | output | N | Flag vector |
| clr_en | output | 1 | Current clear-enable bit |

## Verification
The bench builds the bank with N = 4. This keeps the directed sweep small enough to be exhaustive: every flag index is tried with every combination of break level, clear-enable value, and arm taken or not taken before break. A neighbouring flag is held set throughout each case, to catch cross-flag clears. A long pseudo-random run over the four-flag bank then compares each cycle against an arithmetic model. That run reaches same-cycle collisions of events, arming reads and data accesses that directed cases would miss.

// File: rtl/brkprot_pkg.sv
package brkprot_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_ARM  = 2'd3
  } cell_act_e;

  typedef struct packed {
    logic flag;
    logic arm;
  } cell_state_t;
endpackage

// File: rtl/brkprot_en_reg.sv
module brkprot_en_reg (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic wd,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (we) q <= wd;
  end
endmodule

// File: rtl/brkprot_gate.sv
module brkprot_gate (
  input  logic brk_active,
  input  logic clr_en,
  input  logic stat_rd,
  output logic allow,
  output logic arm_rd
);
  always_comb begin
    allow  = !brk_active || clr_en;
    arm_rd = stat_rd && allow;
  end
endmodule

// File: rtl/brkprot_cell.sv
module brkprot_cell
  import brkprot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic arm_rd,
  input  logic acc,
  input  logic allow,
  output logic flag,
  output logic arm
);
  cell_state_t st_q;
  cell_act_e   act;

  always_comb begin
    if (set_evt)                         act = ACT_SET;
    else if (acc && allow && st_q.arm)   act = ACT_CLR;
    else if (arm_rd && st_q.flag)        act = ACT_ARM;
    else                                 act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      unique case (act)
        ACT_SET:  st_q <= '{flag: 1'b1, arm: 1'b0};
        ACT_CLR:  st_q <= '{flag: 1'b0, arm: 1'b0};
        ACT_ARM:  st_q.arm <= 1'b1;
        default:  st_q <= st_q;
      endcase
    end
  end

  assign flag = st_q.flag;
  assign arm  = st_q.arm;
endmodule

// File: rtl/brkprot_flag_bank.sv
module brkprot_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_set,
  input  logic         brk_active,
  input  logic         en_we,
  input  logic         en_wd,
  input  logic         stat_rd,
  input  logic [N-1:0] data_acc,
  output logic [N-1:0] flags,
  output logic         clr_en
);
  logic         allow;
  logic         arm_rd;
  logic [N-1:0] arm_vec;

  brkprot_en_reg u_en (
    .clk(clk), .rst(rst), .we(en_we), .wd(en_wd), .q(clr_en)
  );

  brkprot_gate u_gate (
    .brk_active(brk_active), .clr_en(clr_en), .stat_rd(stat_rd),
    .allow(allow), .arm_rd(arm_rd)
  );

  for (genvar g = 0; g < N; g++) begin : g_cell
    brkprot_cell u_cell (
      .clk(clk), .rst(rst), .set_evt(evt_set[g]), .arm_rd(arm_rd),
      .acc(data_acc[g]), .allow(allow),
      .flag(flags[g]), .arm(arm_vec[g])
    );
  end
endmodule

// File: rtl/brkprot_flag_bank_chk.sv
module brkprot_flag_bank_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] evt_set,
  input logic         brk_active,
  input logic         en_we,
  input logic         en_wd,
  input logic [N-1:0] data_acc,
  input logic [N-1:0] flags,
  input logic         clr_en
);
  // R1: an event always leaves its flag at 1
  a_r1_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((flags & $past(evt_set)) == $past(evt_set)));

  // R4: protected break never lowers a flag
  a_r4_break_hold: assert property (@(posedge clk) disable iff (rst)
    (brk_active && !clr_en) |=> ((flags & $past(flags)) == $past(flags)));

  // R10: a flag falls only when its own data access was seen
  a_r10_own_access: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((($past(flags) & ~flags) & ~$past(data_acc)) == '0));

  // R9: reset clears the bank and the enable bit
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (flags == '0 && !clr_en));

  // R11: enable bit only moves on a write strobe
  a_r11_en_stable: assert property (@(posedge clk) disable iff (rst)
    !en_we |=> $stable(clr_en));

  // R11: write strobe loads the bit
  a_r11_en_load: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (clr_en == $past(en_wd)));
endmodule

bind brkprot_flag_bank brkprot_flag_bank_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .evt_set(evt_set), .brk_active(brk_active),
  .en_we(en_we), .en_wd(en_wd), .data_acc(data_acc),
  .flags(flags), .clr_en(clr_en)
);

// File: tb/brkprot_flag_bank_bench.sv
module brkprot_flag_bank_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] evt_set, data_acc, flags;
  logic brk_active, en_we, en_wd, stat_rd, clr_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] m_flag, m_arm;
  logic m_en;

  always #2 clk = ~clk;

  brkprot_flag_bank #(.N(N)) u_brkprot_flag_bank (
    .clk(clk), .rst(rst), .evt_set(evt_set), .brk_active(brk_active),
    .en_we(en_we), .en_wd(en_wd), .stat_rd(stat_rd), .data_acc(data_acc),
    .flags(flags), .clr_en(clr_en)
  );

  task automatic chk(input string req, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_set = '0; data_acc = '0; stat_rd = 0; en_we = 0; en_wd = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_reset();
    rst = 1; idle(); brk_active = 0;
    step();
    rst = 0;
  endtask

  // bench model of the requirements, one cycle
  task automatic model_tick();
    logic allow;
    allow = !brk_active || m_en;
    for (int i = 0; i < N; i++) begin
      if (evt_set[i]) begin m_flag[i] = 1; m_arm[i] = 0; end
      else if (data_acc[i] && allow && m_arm[i]) begin m_flag[i] = 0; m_arm[i] = 0; end
      else if (stat_rd && allow && m_flag[i]) m_arm[i] = 1;
    end
    if (en_we) m_en = en_wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; idle(); brk_active = 0;
    step(); step();
    rst = 0;
    chk("R9 reset state", {clr_en, flags}, '0);

    // R11 enable write
    en_we = 1; en_wd = 1; step();
    chk("R11 enable load", {clr_en, flags}, {1'b1, {N{1'b0}}});
    step();
    chk("R11 enable holds", {clr_en, flags}, {1'b1, {N{1'b0}}});

    // R2 unarmed access does not clear; armed does
    do_reset();
    evt_set = 4'b0001; step();
    chk("R1 set", {clr_en, flags}, 5'b00001);
    data_acc = 4'b0001; step();
    chk("R2 unarmed access", {clr_en, flags}, 5'b00001);
    stat_rd = 1; step();
    data_acc = 4'b0001; step();
    chk("R2 two-step clear", {clr_en, flags}, 5'b00000);

    // R3 read while flag 0 does not arm
    do_reset();
    stat_rd = 1; step();
    evt_set = 4'b0010; step();
    data_acc = 4'b0010; step();
    chk("R3 no arm at zero", {clr_en, flags}, 5'b00010);

    // R1 set beats clear in same cycle; R8 arm dropped
    do_reset();
    evt_set = 4'b0100; step();
    stat_rd = 1; step();
    evt_set = 4'b0100; data_acc = 4'b0100; step();
    chk("R1 set wins", {clr_en, flags}, 5'b00100);
    data_acc = 4'b0100; step();
    chk("R8 arm dropped", {clr_en, flags}, 5'b00100);

    // R9 reset clears arm
    evt_set = 4'b0001; step();
    stat_rd = 1; step();
    rst = 1; step(); rst = 0;
    evt_set = 4'b0001; step();
    data_acc = 4'b0001; step();
    chk("R9 arm cleared by reset", {clr_en, flags}, 5'b00001);

    // exhaustive sweep: flag, break, enable, pre-arm
    for (int i = 0; i < N; i++)
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < 2; e++)
          for (int pa = 0; pa < 2; pa++) begin
            logic [N-1:0] me, nb;
            bit cleared;
            me = N'(1) << i;
            nb = N'(1) << ((i + 1) % N);
            do_reset();
            en_we = 1; en_wd = e[0]; evt_set = me | nb; step();
            if (pa) begin stat_rd = 1; step(); end
            brk_active = b[0];
            stat_rd = 1; step();
            data_acc = me; step();
            cleared = (!b[0]) || (e[0] != 0);
            if (b[0] && e[0]) chk("R5 clear in enabled break", {clr_en, flags}, {1'b1, nb});
            else if (b[0])    chk("R4 protected break", {clr_en, flags}, {1'b0, nb | me});
            else              chk("R2 sweep clear R10", {clr_en, flags}, {e[0], nb});
            brk_active = 0; step();
            if (cleared) chk("R6 stays cleared", {clr_en, flags}, {e[0], nb});
            else begin
              data_acc = me; step();
              chk("R7 post-break clear", {clr_en, flags}, {1'b0, pa ? nb : (nb | me)});
            end
          end

    // random run against model
    do_reset();
    m_flag = '0; m_arm = '0; m_en = 0;
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int c = 0; c < 4000; c++) begin
        logic [15:0] r;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        r = lfsr;
        evt_set    = (r[3:0] & {N{r[15] & r[14]}});
        data_acc   = r[7:4];
        stat_rd    = r[8];
        brk_active = (c % 200) > 120;
        en_we      = r[9] & r[10] & r[11];
        en_wd      = r[12];
        model_tick();
        @(posedge clk); #1;
        idle();
        chk("R1 R2 R4 R5 R8 random", {clr_en, flags}, {m_en, m_flag});
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule